// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block is the 32-bit status and interrupt register of a fast Ethernet network controller. Single-cycle event pulses from the transmit engine, the receive engine, the link monitor, the general-purpose timer and the system bus interface are caught in sticky status bits. Two summary bits are formed from fixed groups of those bits, normal and abnormal. The block combines the two summaries with their mask inputs into one interrupt line. The same register word also shows three read-only 3-bit fields: the fatal-error cause, the transmit process state and the receive process state.

Software reads the word on `rd_data_o`. It acknowledges events by writing ones to the bits it wants cleared. Some events count only when mode conditions held in other control registers allow them, and these conditions arrive here as plain level inputs. A fatal bus error also latches `bus_off_o`, which tells the bus interface to stop all further access until reset.

Top module: `nic_irq_status`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `rd_data_o` bits 31:23 and 16:0 read 0, and `irq_o` and `bus_off_o` are 0.
- R2: A pulse on `evt_i` at any of bit positions 0, 1, 2, 3, 5, 6, 7, 8, 9, 10, 11, 13 or 26 sets the same bit of `rd_data_o` after the next rising edge. The bit stays set until it is cleared.
- R3: A write (`wr_en_i` high) clears each sticky bit whose `wr_data_i` bit is 1 and leaves bits written with 0 unchanged.
- R4: When a set and a clear reach the same bit in the same cycle, the set takes priority and the bit reads 1 afterwards.
- R5: Bit 16 is the OR of bits 0, 2, 6 and 28. Bit 15 is the OR of bits 1, 3, 5, 7, 8, 9, 10, 11, 13 and 27. Neither bit can be written.
- R6: `irq_o` equals (bit 16 AND `nis_en_i`) OR (bit 15 AND `ais_en_i`). It follows a change of a mask input in the same cycle.
- R7: Bit 28 (wake-up packet) is set by a `wake_pkt_i` pulse only while `wake_en_i` is 1.
- R8: Bit 12 (10 Mb/s link fail) is set by a `lf10_i` pulse only while `port_sel_i`=0, `ltest_en_i`=1 and `media_mode_i`=0 all hold.
- R9: Bit 14 (early receive) is set by `rx_buf1_i` when `chain_mode_i`=0 and by `rx_64b_i` when `chain_mode_i`=1. The input not selected by the mode has no effect.
- R10: Bit 27 is set whenever `link100_i` changes level in either direction. It stays 0 while the level matches the value sampled during reset.
- R11: Setting bit 13 raises `bus_off_o`. The first such event also captures `err_code_i` into bits 25:23. The flag and the code hold until reset, whatever is written and whatever later errors occur.
- R12: Bits 22:20 show `tx_state_i` and bits 19:17 show `rx_state_i` in the same cycle. Writes do not change them.
- R13: `evt_i` bits other than those listed in R2 have no effect. Bits 31:29 and bit 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for write-one-to-clear |
| wr_data_i | input | 32 | Write data, a 1 clears the matching sticky bit |
| rd_data_o | output | 32 | Register read value |
| evt_i | input | 32 | Unqualified event pulses, one per bit position |
| wake_pkt_i | input | 1 | Wake-up packet received pulse |
| wake_en_i | input | 1 | Wake-up detection enable |
| lf10_i | input | 1 | 10 Mb/s link fail pulse |
| port_sel_i | input | 1 | Port select, must be 0 for link-fail reporting |
| ltest_en_i | input | 1 | Link test enable, must be 1 for link-fail reporting |
| media_mode_i | input | 1 | Media mode, must be 0 for link-fail reporting |
| chain_mode_i | input | 1 | Receive descriptor mode: 0 ring, 1 chain |
| rx_buf1_i | input | 1 | First receive buffer filled pulse |
| rx_64b_i | input | 1 | 64 bytes received pulse |
| link100_i | input | 1 | 100 Mb/s link status level |
| err_code_i | input | 3 | Cause code of a fatal bus error |
| tx_state_i | input | 3 | Transmit process state |
| rx_state_i | input | 3 | Receive process state |
| nis_en_i | input | 1 | Mask for the normal summary |
| ais_en_i | input | 1 | Mask for the abnormal summary |
| irq_o | output | 1 | Interrupt request |
| bus_off_o | output | 1 | Bus access disable, held until reset |

## Verification
Every sticky bit, and the bus-off flag and the captured cause code, changes at the first rising edge after its pulse or write. The summaries and `irq_o` follow the sticky bits combinationally, so they are also due one edge after the stimulus. The state fields and the mask inputs act in the same cycle. The bench applies each stimulus on a falling edge, lets exactly one rising edge pass, and compares on the next falling edge. Checks for same-cycle inputs are made a nanosecond after the input changes, with no clock edge in between.

// File: rtl/nic_irq_pkg.sv
// Shared constants for the interrupt status register: bit positions that
// neighbouring logic decodes, and the group masks derived from them.
package nic_irq_pkg;
    localparam int REG_W  = 32;
    localparam int FLD_W  = 3;

    localparam int B_NIS  = 16;
    localparam int B_AIS  = 15;
    localparam int B_WAKE = 28;
    localparam int B_LCHG = 27;
    localparam int B_ERI  = 14;
    localparam int B_FBE  = 13;
    localparam int B_LF10 = 12;

    localparam int ERR_LO = 23;
    localparam int TX_LO  = 20;
    localparam int RX_LO  = 17;

    // bits feeding the normal summary: 0, 2, 6, 28
    localparam logic [REG_W-1:0] NORM_GRP  = 32'h1000_0045;
    // bits feeding the abnormal summary: 1, 3, 5, 7..11, 13, 27
    localparam logic [REG_W-1:0] ABN_GRP   = 32'h0800_2FAA;
    // events taken straight from evt_i
    localparam logic [REG_W-1:0] PLAIN_EVT = 32'h0400_2FEF;
    // events produced by qualification logic
    localparam logic [REG_W-1:0] QUAL_EVT  = (32'h1 << B_WAKE) | (32'h1 << B_LCHG) |
                                             (32'h1 << B_ERI)  | (32'h1 << B_LF10);
    localparam logic [REG_W-1:0] STICKY    = PLAIN_EVT | QUAL_EVT;
endpackage

// File: rtl/nic_irq_qual.sv
// Event qualification. Turns raw pulses and levels into one set vector for
// the sticky bank. Assumes every pulse input is high for one cycle per event.
module nic_irq_qual
    import nic_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             wake_pkt_i,
    input  logic             wake_en_i,
    input  logic             lf10_i,
    input  logic             port_sel_i,
    input  logic             ltest_en_i,
    input  logic             media_mode_i,
    input  logic             chain_mode_i,
    input  logic             rx_buf1_i,
    input  logic             rx_64b_i,
    input  logic             link100_i,
    output logic [REG_W-1:0] set_o
);
    logic link_prev_q;

    // Remember the last link level; reset seeds it with the present level.
    always_ff @(posedge clk) begin
        link_prev_q <= link100_i;
    end

    // Merge direct events with the mode-gated ones.
    always_comb begin
        set_o         = evt_i & PLAIN_EVT;
        set_o[B_WAKE] = wake_pkt_i & wake_en_i;
        set_o[B_LF10] = lf10_i & ~port_sel_i & ltest_en_i & ~media_mode_i;
        set_o[B_ERI]  = chain_mode_i ? rx_64b_i : rx_buf1_i;
        set_o[B_LCHG] = rst_n & (link100_i ^ link_prev_q);
    end
endmodule

// File: rtl/nic_irq_sticky.sv
// Sticky status bank. Holds one flop per implemented event bit. A set beats
// a write-one-to-clear in the same cycle. Unimplemented bits read as 0.
module nic_irq_sticky
    import nic_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP = STICKY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] q_o
);
    logic [REG_W-1:0] q_r;

    // Clear first, then apply sets, so that an event survives a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= ((q_r & ~clr_i) | set_i) & KEEP;
    end

    assign q_o = q_r;
endmodule

// File: rtl/nic_irq_summary.sv
// Summary and interrupt logic. Reduces the sticky bits to the two group
// summaries and gates each one with its mask. Purely combinational.
module nic_irq_summary
    import nic_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] NGRP = NORM_GRP,
    parameter logic [REG_W-1:0] AGRP = ABN_GRP
) (
    input  logic [REG_W-1:0] st_i,
    input  logic             nis_en_i,
    input  logic             ais_en_i,
    output logic             nis_o,
    output logic             ais_o,
    output logic             irq_o
);
    // OR-reduce each group, then apply the masks.
    always_comb begin
        nis_o = |(st_i & NGRP);
        ais_o = |(st_i & AGRP);
        irq_o = (nis_o & nis_en_i) | (ais_o & ais_en_i);
    end
endmodule

// File: rtl/nic_irq_status.sv
// Top of the interrupt status register. Wires qualification, the sticky bank
// and the summaries together. Holds the bus-off flag and the captured error
// cause, and assembles the read word. Assumes a single clock domain.
module nic_irq_status
    import nic_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic [REG_W-1:0] evt_i,
    input  logic             wake_pkt_i,
    input  logic             wake_en_i,
    input  logic             lf10_i,
    input  logic             port_sel_i,
    input  logic             ltest_en_i,
    input  logic             media_mode_i,
    input  logic             chain_mode_i,
    input  logic             rx_buf1_i,
    input  logic             rx_64b_i,
    input  logic             link100_i,
    input  logic [FLD_W-1:0] err_code_i,
    input  logic [FLD_W-1:0] tx_state_i,
    input  logic [FLD_W-1:0] rx_state_i,
    input  logic             nis_en_i,
    input  logic             ais_en_i,
    output logic             irq_o,
    output logic             bus_off_o
);
    logic [REG_W-1:0] set_w;
    logic [REG_W-1:0] clr_w;
    logic [REG_W-1:0] st_w;
    logic             nis_w;
    logic             ais_w;
    logic             bus_off_q;
    logic [FLD_W-1:0] err_q;

    assign clr_w = wr_en_i ? wr_data_i : '0;

    nic_irq_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .wake_pkt_i   (wake_pkt_i),
        .wake_en_i    (wake_en_i),
        .lf10_i       (lf10_i),
        .port_sel_i   (port_sel_i),
        .ltest_en_i   (ltest_en_i),
        .media_mode_i (media_mode_i),
        .chain_mode_i (chain_mode_i),
        .rx_buf1_i    (rx_buf1_i),
        .rx_64b_i     (rx_64b_i),
        .link100_i    (link100_i),
        .set_o        (set_w)
    );

    nic_irq_sticky #(.KEEP(STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_w),
        .clr_i (clr_w),
        .q_o   (st_w)
    );

    nic_irq_summary #(.NGRP(NORM_GRP), .AGRP(ABN_GRP)) u_sum (
        .st_i     (st_w),
        .nis_en_i (nis_en_i),
        .ais_en_i (ais_en_i),
        .nis_o    (nis_w),
        .ais_o    (ais_w),
        .irq_o    (irq_o)
    );

    // Latch bus-off on a fatal error and keep the cause of the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_off_q <= 1'b0;
            err_q     <= '0;
        end else if (set_w[B_FBE]) begin
            bus_off_q <= 1'b1;
            if (!bus_off_q) err_q <= err_code_i;
        end
    end

    // Assemble the read word from the sticky bits, summaries and fields.
    always_comb begin
        rd_data_o                    = st_w;
        rd_data_o[B_NIS]             = nis_w;
        rd_data_o[B_AIS]             = ais_w;
        rd_data_o[ERR_LO +: FLD_W]   = err_q;
        rd_data_o[TX_LO +: FLD_W]    = tx_state_i;
        rd_data_o[RX_LO +: FLD_W]    = rx_state_i;
    end

    assign bus_off_o = bus_off_q;
endmodule

// File: rtl/nic_irq_status_chk.sv
// Property checker for nic_irq_status. Observes ports only and is attached
// to every instance of the top through the bind below.
module nic_irq_status_chk
    import nic_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [REG_W-1:0] evt_i,
    input logic             wake_pkt_i,
    input logic             wake_en_i,
    input logic             nis_en_i,
    input logic             ais_en_i,
    input logic             irq_o,
    input logic             bus_off_o
);
    // R11
    fbe_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[B_FBE]) |-> bus_off_o);

    // R11
    busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_o |=> bus_off_o);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[0] && !evt_i[0]) |=> !rd_data_o[0]);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[0] && !(wr_en_i && wr_data_i[0])) |=> rd_data_o[0]);

    // R7
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data_o[B_WAKE] && !(wake_pkt_i && wake_en_i)) |=> !rd_data_o[B_WAKE]);

    // R6
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((rd_data_o[B_NIS] && nis_en_i) || (rd_data_o[B_AIS] && ais_en_i)));

    // R13
    rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[31:29] == 3'b000) && !rd_data_o[4]);
endmodule

bind nic_irq_status nic_irq_status_chk u_chk (.*);

// File: tb/test_nic_irq_status.sv
`timescale 1ns/1ps
module test_nic_irq_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [31:0] evt;
    logic        wake_pkt, wake_en, lf10, port_sel, ltest_en, media_mode;
    logic        chain_mode, rx_buf1, rx_64b, link100;
    logic [2:0]  err_code, tx_state, rx_state;
    logic        nis_en, ais_en, irq, bus_off;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nic_irq_status i_nic_irq_status (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .evt_i(evt), .wake_pkt_i(wake_pkt),
        .wake_en_i(wake_en), .lf10_i(lf10), .port_sel_i(port_sel),
        .ltest_en_i(ltest_en), .media_mode_i(media_mode),
        .chain_mode_i(chain_mode), .rx_buf1_i(rx_buf1), .rx_64b_i(rx_64b),
        .link100_i(link100), .err_code_i(err_code), .tx_state_i(tx_state),
        .rx_state_i(rx_state), .nis_en_i(nis_en), .ais_en_i(ais_en),
        .irq_o(irq), .bus_off_o(bus_off)
    );

    // {evt, wr_en, wr_data, expected read word}
    typedef logic [96:0] vec_t;
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        {32'h0000_0001, 1'b0, 32'h0000_0000, 32'h0001_0001}, // R2 R5 bit0
        {32'h0000_0002, 1'b0, 32'h0000_0000, 32'h0001_8003}, // R2 R5 bit1
        {32'h0000_0000, 1'b1, 32'h0000_0001, 32'h0000_8002}, // R3 clear bit0
        {32'h0000_0002, 1'b1, 32'h0000_0002, 32'h0000_8002}, // R4 set wins
        {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R3 R5 R12
        {32'h0000_0440, 1'b0, 32'h0000_0000, 32'h0001_8440}, // R2 bits 6,10
        {32'h0400_0000, 1'b0, 32'h0000_0000, 32'h0401_8440}, // R2 bit26
        {32'h0000_0000, 1'b1, 32'h0000_0040, 32'h0400_8400}, // R3 R5
        {32'hFBFF_D010, 1'b0, 32'h0000_0000, 32'h0400_8400}, // R13 ignored
        {32'h0000_0000, 1'b1, 32'h0400_0400, 32'h0000_0000}, // R3
        {32'h0000_0BAC, 1'b0, 32'h0000_0000, 32'h0001_8BAC}, // R2 R5
        {32'h0000_0000, 1'b1, 32'h0000_0004, 32'h0000_8BA8}, // R3 R5
        {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}  // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_pulses;
        evt = '0; wr_en = 1'b0; wr_data = '0;
        wake_pkt = 1'b0; lf10 = 1'b0; rx_buf1 = 1'b0; rx_64b = 1'b0;
    endtask

    // one rising edge, then back to a falling edge with pulses dropped
    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        idle_pulses();
    endtask

    task automatic wipe;
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        tick();
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_pulses();
        wake_en = 0; port_sel = 0; ltest_en = 0; media_mode = 0;
        chain_mode = 0; link100 = 1'b1; err_code = 3'd0;
        tx_state = 3'd0; rx_state = 3'd0; nis_en = 1'b1; ais_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        tick();

        // R1 reset state
        chk("R1 read word", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 bus_off", {31'b0, bus_off}, 32'h0);
        // R10 link level equal to reset value: no change flagged
        chk("R10 steady link", {31'b0, rd_data[27]}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            evt     = VEC[i][96:65];
            wr_en   = VEC[i][64];
            wr_data = VEC[i][63:32];
            tick();
            chk($sformatf("vector %0d (R2 R3 R4 R5 R13)", i), rd_data, VEC[i][31:0]);
            chk($sformatf("vector %0d irq R6", i), {31'b0, irq},
                {31'b0, VEC[i][16] | VEC[i][15]});
        end

        // R6 masks act in the same cycle
        evt = 32'h1; tick();
        nis_en = 1'b0; #1;
        chk("R6 nis masked", {31'b0, irq}, 32'h0);
        evt = 32'h2; tick();
        chk("R6 ais unmasked", {31'b0, irq}, 32'h1);
        ais_en = 1'b0; #1;
        chk("R6 both masked", {31'b0, irq}, 32'h0);
        nis_en = 1'b1; #1;
        chk("R6 nis unmasked", {31'b0, irq}, 32'h1);
        ais_en = 1'b1;
        wipe();

        // R7 wake-up gating
        wake_pkt = 1'b1; tick();
        chk("R7 wake disabled", rd_data, 32'h0);
        wake_en = 1'b1; wake_pkt = 1'b1; tick();
        chk("R7 wake enabled", rd_data, 32'h1001_0000);
        wake_en = 1'b0;
        wipe();

        // R8 link-fail qualification
        lf10 = 1'b1; tick();
        chk("R8 test disabled", rd_data, 32'h0);
        ltest_en = 1'b1; port_sel = 1'b1; lf10 = 1'b1; tick();
        chk("R8 port selected", rd_data, 32'h0);
        port_sel = 1'b0; media_mode = 1'b1; lf10 = 1'b1; tick();
        chk("R8 media mode", rd_data, 32'h0);
        media_mode = 1'b0; lf10 = 1'b1; tick();
        chk("R8 qualified", rd_data, 32'h0000_1000);
        ltest_en = 1'b0;
        wipe();

        // R9 early receive per mode
        rx_64b = 1'b1; tick();
        chk("R9 ring ignores 64B", rd_data, 32'h0);
        rx_buf1 = 1'b1; tick();
        chk("R9 ring first buffer", rd_data, 32'h0000_4000);
        wipe();
        chain_mode = 1'b1; rx_buf1 = 1'b1; tick();
        chk("R9 chain ignores buffer", rd_data, 32'h0);
        rx_64b = 1'b1; tick();
        chk("R9 chain 64B", rd_data, 32'h0000_4000);
        chain_mode = 1'b0;
        wipe();

        // R10 link change both ways
        link100 = 1'b0; tick();
        chk("R10 pass to fail", rd_data, 32'h0800_8000);
        wipe();
        chk("R10 no change", rd_data, 32'h0);
        link100 = 1'b1; tick();
        chk("R10 fail to pass", rd_data, 32'h0800_8000);
        wipe();

        // R12 state fields pass through and ignore writes
        tx_state = 3'd5; rx_state = 3'd3; #1;
        chk("R12 fields", rd_data, 32'h0056_0000);
        wr_en = 1'b1; wr_data = 32'h007E_0000; tick();
        chk("R12 write ignored", rd_data, 32'h0056_0000);
        tx_state = 3'd0; rx_state = 3'd0;

        // R11 fatal bus error
        err_code = 3'd6; evt = 32'h0000_2000; tick();
        chk("R11 fatal set", rd_data, 32'h0300_A000);
        chk("R11 bus_off", {31'b0, bus_off}, 32'h1);
        err_code = 3'd1; evt = 32'h0000_2000; tick();
        chk("R11 first cause kept", rd_data, 32'h0300_A000);
        wipe();
        chk("R11 cleared bit, code held", rd_data, 32'h0300_0000);
        chk("R11 bus_off held", {31'b0, bus_off}, 32'h1);
        do_reset();
        tick();
        chk("R11 R1 reset clears code", rd_data, 32'h0);
        chk("R11 R1 reset clears bus_off", {31'b0, bus_off}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule